// File: doc/BRIEF.md
# Cache Maintenance Access Port

This block gives software direct reach into the tag and data arrays of a 4-way set-associative cache. It does this through ordinary load and store cycles aimed at a reserved address window. Two such caches are held inside the block, one for instructions and one for operands. Each has 128 sets of 16-byte lines. The access address is decoded into four things:

- which cache is addressed;
- whether the tag/status array or the line data is meant;
- the set index, together with either the way and longword offset or an associative flag;
- nothing else is encoded, so any address outside the window is ignored.

A store to the tag/status array can go one of two ways. It can overwrite a way directly. Or it can look up the tag carried in the store data among the ways of the set and change only the valid and dirty bits of the way that matches. When a store clears the valid bit of a line that is dirty, the block first issues a write-back request with a valid/ready handshake. That request carries the line address and all four longwords. The access is only acknowledged once that request has been taken.

Top module: `cmp_port`

## Requirements
- R1: An access is inside the window only when addr[31:25] is 7'b1111000, addr[22:13] is zero and addr[1:0] is zero. Any other access is acknowledged, changes nothing, and a load from it returns 0.
- R2: Inside the window, addr[24] selects the cache (0 operand, 1 instruction) and addr[23] selects the array (1 tag/status, 0 data). A data-array store writes, and a data-array load returns, the longword at set addr[10:4], way addr[12:11], longword addr[3:2].
- R3: A tag/status store with addr[3]=0 writes tag = wdata[28:11], dirty = wdata[1] and valid = wdata[0] into way addr[12:11] of set addr[10:4]. A tag/status load returns {3'b0, tag, 9'b0, dirty, valid} for that way.
- R4: A tag/status store with addr[3]=1 compares wdata[28:11] with the tags of all ways of set addr[10:4]. On a match it writes wdata[1] and wdata[0] into the dirty and valid bits of the matching way (lowest way on a tie) and leaves the tag as it was.
- R5: An associative store whose tag matches no way of the set changes no way of that set.
- R6: A tag/status store that writes valid=0 into a way whose dirty bit is 1 raises wb_valid_o. It carries wb_addr_o = {3'b0, old tag, set, 4'b0} and wb_data_o = the line, with longword 0 in bits 31:0. These values are held until wb_ready_i. The status change and ack_o come only after acceptance.
- R7: A store that clears valid on a clean way, or clears only the dirty bit, raises no write-back request.
- R8: Reset (synchronous, active low) clears every tag, valid and dirty bit, and leaves ack_o and wb_valid_o low.
- R9: Each request is performed once and answered by ack_o high for exactly one cycle. Without a write-back, ack_o rises one cycle after the request is first seen. rdata_o is valid while ack_o is high and is 0 for stores.
- R10: The two caches are independent: an access to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 store, 0 load |
| addr_i | input | 32 | Access address |
| wdata_i | input | 32 | Store data |
| ack_o | output | 1 | One-cycle access completion |
| rdata_o | output | 32 | Load data, valid with ack_o |
| wb_valid_o | output | 1 | Write-back request pending |
| wb_ready_i | input | 1 | Write-back request accepted |
| wb_addr_o | output | 32 | Byte address of the line to write back |
| wb_data_o | output | 128 | Line contents, longword 0 lowest |

## Verification
The associative store is tried with four kinds of tag and status pattern:

- a tag that matches no way, which tells a miss apart from a write to the addressed way;
- a matching tag that only sets the dirty bit;
- a matching tag that clears the dirty bit alone;
- a matching tag that clears valid on a dirty line, which is the only pattern that may produce a write-back.

A direct store that clears valid on a dirty line checks that the write-back carries the old tag rather than the newly written one. Data-array traffic uses different ways and longwords in the same set, which separates the way and offset fields. Identical offsets sent to the other cache and to addresses just outside the window show that nothing leaks across.

// File: rtl/cmp_pkg.sv
// Shared constants and types of the cache maintenance port.
// Assumes a 32-bit access address with the field layout given in the brief.
package cmp_pkg;
    localparam int unsigned CMP_IDX_W  = 7;
    localparam int unsigned CMP_WAYS   = 4;
    localparam int unsigned CMP_WORDS  = 4;
    localparam int unsigned CMP_TAG_W  = 18;
    localparam int unsigned CMP_WAY_W  = $clog2(CMP_WAYS);
    localparam int unsigned CMP_WORD_W = $clog2(CMP_WORDS);
    localparam int unsigned CMP_SETS   = 1 << CMP_IDX_W;
    localparam int unsigned CMP_TAG_LSB = 11;
    localparam logic [6:0]  CMP_WIN_HI  = 7'b1111_000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_DONE = 2'd2
    } cmp_state_e;

    typedef struct packed {
        logic                  in_win;
        logic                  icache;
        logic                  addr_arr;
        logic                  assoc;
        logic [CMP_IDX_W-1:0]  idx;
        logic [CMP_WAY_W-1:0]  way;
        logic [CMP_WORD_W-1:0] word;
    } cmp_dec_t;
endpackage

// File: rtl/cmp_decode.sv
// Splits a maintenance access address into cache, array, set, way,
// longword and associative-flag fields. Purely combinational.
// Assumes the reserved bits must be zero for an in-window access.
module cmp_decode
    import cmp_pkg::*;
(
    input  logic [31:0] addr_i,
    output cmp_dec_t    dec_o
);
    // Field extraction and window qualification.
    always_comb begin
        dec_o.in_win   = (addr_i[31:25] == CMP_WIN_HI) &&
                         (addr_i[22:13] == '0) && (addr_i[1:0] == 2'b00);
        dec_o.icache   = addr_i[24];
        dec_o.addr_arr = addr_i[23];
        dec_o.assoc    = addr_i[3];
        dec_o.idx      = addr_i[4 +: CMP_IDX_W];
        dec_o.way      = addr_i[CMP_TAG_LSB +: CMP_WAY_W];
        dec_o.word     = addr_i[2 +: CMP_WORD_W];
    end
endmodule

// File: rtl/cmp_bank.sv
// Storage of one cache: tag, valid and dirty bits per way and set, plus
// the line data. Reads are combinational for one set; the tag/status
// write port and the data write port are independent.
// Assumes at most one tag/status write and one data write per cycle.
module cmp_bank #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WORDS = 4,
    parameter int unsigned TAG_W = 18,
    localparam int unsigned WAY_W  = $clog2(WAYS),
    localparam int unsigned WORD_W = $clog2(WORDS),
    localparam int unsigned SETS   = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [WAY_W-1:0]             way_i,
    output logic [WAYS-1:0][TAG_W-1:0]   tags_o,
    output logic [WAYS-1:0]              u_o,
    output logic [WAYS-1:0]              v_o,
    output logic [WORDS-1:0][31:0]       line_o,
    input  logic                         st_we_i,
    input  logic [IDX_W-1:0]             st_idx_i,
    input  logic [WAY_W-1:0]             st_way_i,
    input  logic                         st_tag_we_i,
    input  logic [TAG_W-1:0]             st_tag_i,
    input  logic                         st_u_i,
    input  logic                         st_v_i,
    input  logic                         dt_we_i,
    input  logic [WORD_W-1:0]            dt_word_i,
    input  logic [31:0]                  dt_val_i
);
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0]            u_q   [SETS];
    logic [WAYS-1:0]            v_q   [SETS];
    logic [31:0]                data_q [SETS][WAYS][WORDS];

    // Tag and status array: cleared by reset, one way written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                u_q[s]   <= '0;
                v_q[s]   <= '0;
            end
        end else if (st_we_i) begin
            u_q[st_idx_i][st_way_i] <= st_u_i;
            v_q[st_idx_i][st_way_i] <= st_v_i;
            if (st_tag_we_i) begin
                tag_q[st_idx_i][st_way_i] <= st_tag_i;
            end
        end
    end

    // Line data: one longword written per cycle, no reset.
    always_ff @(posedge clk) begin
        if (dt_we_i) begin
            data_q[idx_i][way_i][dt_word_i] <= dt_val_i;
        end
    end

    // Read of the addressed set and of one line of it.
    always_comb begin
        tags_o = tag_q[idx_i];
        u_o    = u_q[idx_i];
        v_o    = v_q[idx_i];
        for (int k = 0; k < WORDS; k++) begin
            line_o[k] = data_q[idx_i][way_i][k];
        end
    end
endmodule

// File: rtl/cmp_match.sv
// Compares a lookup tag with every way of a set and reports a hit and
// the lowest matching way. Combinational.
module cmp_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 18,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           key_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    // Scan from the top way down so the lowest match wins.
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (tags_i[w] == key_i) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cmp_port.sv
// Cache maintenance access port: decodes load/store accesses to the
// reserved window and performs direct or associative tag/status writes
// and longword data accesses on an instruction and an operand cache.
// A status write that invalidates a dirty line is held back until a
// write-back request for that line has been accepted.
// Assumes the requester holds req_i, we_i, addr_i and wdata_i stable
// until it sees ack_o.
module cmp_port
    import cmp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic                      we_i,
    input  logic [31:0]               addr_i,
    input  logic [31:0]               wdata_i,
    output logic                      ack_o,
    output logic [31:0]               rdata_o,
    output logic                      wb_valid_o,
    input  logic                      wb_ready_i,
    output logic [31:0]               wb_addr_o,
    output logic [CMP_WORDS*32-1:0]   wb_data_o
);
    localparam int unsigned NCACHE = 2;
    localparam int unsigned LINE_W = CMP_WORDS * 32;
    localparam int unsigned OFF_W  = $clog2(CMP_WORDS * 4);

    cmp_dec_t   dec;
    cmp_state_e state_q;

    logic [CMP_WAYS-1:0][CMP_TAG_W-1:0] tags_b [NCACHE];
    logic [CMP_WAYS-1:0]                u_b    [NCACHE];
    logic [CMP_WAYS-1:0]                v_b    [NCACHE];
    logic [CMP_WORDS-1:0][31:0]         line_b [NCACHE];

    logic [CMP_WAYS-1:0][CMP_TAG_W-1:0] tags_s;
    logic [CMP_WAYS-1:0]                u_s, v_s;
    logic [CMP_WORDS-1:0][31:0]         line_s;

    logic [CMP_TAG_W-1:0] key;
    logic                 m_hit;
    logic [CMP_WAY_W-1:0] m_way, rd_way;
    logic                 idle_go, aa_wr, st_go, need_wb, dt_go, new_u, new_v;
    logic [31:0]          rd_word;

    logic                 pend_sel, pend_tag_we, pend_u, pend_v;
    logic [CMP_IDX_W-1:0] pend_idx;
    logic [CMP_WAY_W-1:0] pend_way;
    logic [CMP_TAG_W-1:0] pend_tag;

    logic                 st_fire, st_sel, st_tag_we, st_u, st_v;
    logic [CMP_IDX_W-1:0] st_idx;
    logic [CMP_WAY_W-1:0] st_way;
    logic [CMP_TAG_W-1:0] st_tag;

    logic                 ack_q;
    logic [31:0]          rdata_q, wb_addr_q;
    logic [LINE_W-1:0]    wb_data_q;

    cmp_decode u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    // Selected cache view and store-data fields.
    always_comb begin
        tags_s = tags_b[dec.icache];
        u_s    = u_b[dec.icache];
        v_s    = v_b[dec.icache];
        line_s = line_b[dec.icache];
        key    = wdata_i[CMP_TAG_LSB +: CMP_TAG_W];
        new_u  = wdata_i[1];
        new_v  = wdata_i[0];
    end

    cmp_match #(
        .WAYS  (CMP_WAYS),
        .TAG_W (CMP_TAG_W)
    ) u_match (
        .tags_i (tags_s),
        .key_i  (key),
        .hit_o  (m_hit),
        .way_o  (m_way)
    );

    // Access classification for the request seen in the idle state.
    always_comb begin
        idle_go = (state_q == ST_IDLE) && req_i;
        aa_wr   = dec.in_win && dec.addr_arr && we_i;
        rd_way  = (aa_wr && dec.assoc) ? m_way : dec.way;
        st_go   = aa_wr && (!dec.assoc || m_hit);
        need_wb = st_go && !new_v && u_s[rd_way];
        dt_go   = dec.in_win && !dec.addr_arr && we_i;
    end

    // Load data for the current access.
    always_comb begin
        if (!dec.in_win) begin
            rd_word = '0;
        end else if (dec.addr_arr) begin
            rd_word = (32'(tags_s[dec.way]) << CMP_TAG_LSB) |
                      {30'b0, u_s[dec.way], v_s[dec.way]};
        end else begin
            rd_word = line_s[dec.word];
        end
    end

    // Tag/status write port: immediate update or the pending one after write-back.
    always_comb begin
        st_fire = (idle_go && st_go && !need_wb) ||
                  (state_q == ST_WB && wb_ready_i);
        if (state_q == ST_WB) begin
            st_sel    = pend_sel;
            st_idx    = pend_idx;
            st_way    = pend_way;
            st_tag_we = pend_tag_we;
            st_tag    = pend_tag;
            st_u      = pend_u;
            st_v      = pend_v;
        end else begin
            st_sel    = dec.icache;
            st_idx    = dec.idx;
            st_way    = rd_way;
            st_tag_we = !dec.assoc;
            st_tag    = key;
            st_u      = new_u;
            st_v      = new_v;
        end
    end

    for (genvar c = 0; c < NCACHE; c++) begin : g_bank
        cmp_bank #(
            .IDX_W (CMP_IDX_W),
            .WAYS  (CMP_WAYS),
            .WORDS (CMP_WORDS),
            .TAG_W (CMP_TAG_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .idx_i       (dec.idx),
            .way_i       (rd_way),
            .tags_o      (tags_b[c]),
            .u_o         (u_b[c]),
            .v_o         (v_b[c]),
            .line_o      (line_b[c]),
            .st_we_i     (st_fire && (st_sel == 1'(c))),
            .st_idx_i    (st_idx),
            .st_way_i    (st_way),
            .st_tag_we_i (st_tag_we),
            .st_tag_i    (st_tag),
            .st_u_i      (st_u),
            .st_v_i      (st_v),
            .dt_we_i     (idle_go && dt_go && (dec.icache == 1'(c))),
            .dt_word_i   (dec.word),
            .dt_val_i    (wdata_i)
        );
    end

    // Access sequencing: accept, optional write-back wait, one-cycle ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ack_q       <= 1'b0;
            rdata_q     <= '0;
            wb_addr_q   <= '0;
            wb_data_q   <= '0;
            pend_sel    <= 1'b0;
            pend_idx    <= '0;
            pend_way    <= '0;
            pend_tag_we <= 1'b0;
            pend_tag    <= '0;
            pend_u      <= 1'b0;
            pend_v      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        if (need_wb) begin
                            state_q     <= ST_WB;
                            wb_addr_q   <= 32'({tags_s[rd_way], dec.idx, OFF_W'(0)});
                            wb_data_q   <= line_s;
                            pend_sel    <= dec.icache;
                            pend_idx    <= dec.idx;
                            pend_way    <= rd_way;
                            pend_tag_we <= !dec.assoc;
                            pend_tag    <= key;
                            pend_u      <= new_u;
                            pend_v      <= new_v;
                        end else begin
                            state_q <= ST_DONE;
                            ack_q   <= 1'b1;
                            rdata_q <= we_i ? '0 : rd_word;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_ready_i) begin
                        state_q <= ST_DONE;
                        ack_q   <= 1'b1;
                        rdata_q <= '0;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                    ack_q   <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ack_o      = ack_q;
    assign rdata_o    = rdata_q;
    assign wb_valid_o = (state_q == ST_WB);
    assign wb_addr_o  = wb_addr_q;
    assign wb_data_o  = wb_data_q;
endmodule

// File: rtl/cmp_port_chk.sv
// Protocol checker for cmp_port, attached through bind.
// Assumes the requester holds its request fields until ack_o.
module cmp_port_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         req_i,
    input logic         we_i,
    input logic [31:0]  addr_i,
    input logic         ack_o,
    input logic [31:0]  rdata_o,
    input logic         wb_valid_o,
    input logic         wb_ready_i,
    input logic [31:0]  wb_addr_o,
    input logic [127:0] wb_data_o
);
    // R9: acknowledge lasts one cycle.
    a_r9_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R6: a write-back request holds its contents until accepted.
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));

    // R6: no acknowledge while the write-back is outstanding.
    a_r6_no_ack_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> !ack_o);

    // R6: a write-back only starts from a tag/status store.
    a_r6_wb_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid_o) |-> (req_i && we_i && addr_i[23]));

    // R1: loads outside the window return zero.
    a_r1_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !we_i && (addr_i[31:25] != 7'b1111000)) |-> (rdata_o == 32'd0));

    // R8: reset leaves the handshake outputs low.
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ack_o && !wb_valid_o));
endmodule

bind cmp_port cmp_port_chk u_chk (.*);

// File: tb/cmp_port_test.sv
// Scoreboard bench for cmp_port: driver tasks queue expected load data
// and write-back items, monitor processes compare them as they appear.
module cmp_port_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0, we = 1'b0, wb_ready = 1'b0;
    logic [31:0]  addr = '0, wdata = '0;
    logic         ack, wb_valid;
    logic [31:0]  rdata, wb_addr;
    logic [127:0] wb_data;

    int checks = 0, fails = 0;
    bit rd_pending = 1'b0;
    logic [31:0]  exp_rd_q[$];
    string        exp_rd_tag[$];
    logic [31:0]  exp_wb_a[$];
    logic [127:0] exp_wb_d[$];
    string        exp_wb_tag[$];

    localparam logic [17:0] T1 = 18'h2_1A5C;
    localparam logic [17:0] T2 = 18'h0_3F01;
    localparam logic [17:0] T3 = 18'h1_0000;

    always #5 clk = ~clk;

    cmp_port uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .wb_valid_o(wb_valid),
        .wb_ready_i(wb_ready), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] aa_addr(input bit ic, input int idx, input int way, input bit assoc);
        return {7'b1111000, ic, 1'b1, 10'b0, 2'(way), 7'(idx), assoc, 3'b000};
    endfunction

    function automatic logic [31:0] da_addr(input bit ic, input int idx, input int way, input int word);
        return {7'b1111000, ic, 1'b0, 10'b0, 2'(way), 7'(idx), 2'(word), 2'b00};
    endfunction

    function automatic logic [31:0] aa_wd(input logic [17:0] tag, input bit u, input bit v);
        return {3'b000, tag, 9'b0, u, v};
    endfunction

    task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        do @(negedge clk); while (!ack);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        exp_rd_q.push_back(exp);
        exp_rd_tag.push_back(tag);
        rd_pending = 1'b1;
        access(1'b0, a, 32'd0);
        rd_pending = 1'b0;
    endtask

    task automatic expect_wb(input logic [31:0] a, input logic [127:0] d, input string tag);
        exp_wb_a.push_back(a);
        exp_wb_d.push_back(d);
        exp_wb_tag.push_back(tag);
    endtask

    // Load monitor: compares returned data while ack is high.
    initial forever begin
        @(posedge clk); #2;
        if (ack && rd_pending) begin
            if (exp_rd_q.size() == 0) begin
                check(1'b0, "R9 unexpected load", rdata, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_rd_q.pop_front();
                t = exp_rd_tag.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    // Write-back responder: waits 3 cycles, checks the stall, then accepts.
    initial begin
        int waits = 0;
        forever begin
            @(posedge clk); #2;
            if (wb_valid && !wb_ready) begin
                waits++;
                if (waits == 3) begin
                    check(ack == 1'b0, "R6 stall", ack, 0);
                    if (exp_wb_a.size() == 0) begin
                        check(1'b0, "R7 unexpected write-back", wb_addr, 0);
                    end else begin
                        logic [31:0]  ea;
                        logic [127:0] ed;
                        string t;
                        ea = exp_wb_a.pop_front();
                        ed = exp_wb_d.pop_front();
                        t  = exp_wb_tag.pop_front();
                        check(wb_addr === ea, {t, " addr"}, wb_addr, ea);
                        check(wb_data === ed, {t, " data"}, wb_data, ed);
                    end
                    wb_ready = 1'b1;
                    @(posedge clk); #2;
                    wb_ready = 1'b0;
                    waits = 0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ack == 1'b0 && wb_valid == 1'b0, "R8 outputs in reset", {ack, wb_valid}, 0);
        rst_n = 1'b1;

        // R8: status cleared
        rd(aa_addr(0, 8, 1, 0), 32'd0, "R8");
        rd(aa_addr(1, 127, 3, 0), 32'd0, "R8");

        // R2: data array fields
        for (int k = 0; k < 4; k++) wr(da_addr(0, 8, 1, k), 32'hA0A0_0000 + k * 32'h1111);
        wr(da_addr(0, 8, 2, 2), 32'hDEAD_BEEF);
        rd(da_addr(0, 8, 1, 2), 32'hA0A0_2222, "R2");
        rd(da_addr(0, 8, 2, 2), 32'hDEAD_BEEF, "R2");
        rd(da_addr(0, 8, 1, 0), 32'hA0A0_0000, "R2");

        // R9: ack drops after one cycle
        @(negedge clk);
        check(ack == 1'b0, "R9 single ack", ack, 0);

        // R3: direct tag/status store
        wr(aa_addr(0, 8, 1, 0), aa_wd(T1, 1, 1));
        rd(aa_addr(0, 8, 1, 0), aa_wd(T1, 1, 1), "R3");

        // R5: associative miss
        wr(aa_addr(0, 8, 1, 1), aa_wd(T3, 0, 0));
        rd(aa_addr(0, 8, 1, 0), aa_wd(T1, 1, 1), "R5");

        // R4: associative hit sets dirty, tag kept
        wr(aa_addr(0, 9, 2, 0), aa_wd(T2, 0, 1));
        wr(aa_addr(0, 9, 0, 1), aa_wd(T2, 1, 1));
        rd(aa_addr(0, 9, 2, 0), aa_wd(T2, 1, 1), "R4");

        // R6: associative invalidate of dirty line
        expect_wb({3'b000, T1, 7'd8, 4'b0},
                  {32'hA0A0_3333, 32'hA0A0_2222, 32'hA0A0_1111, 32'hA0A0_0000}, "R6 assoc");
        wr(aa_addr(0, 8, 3, 1), aa_wd(T1, 0, 0));
        rd(aa_addr(0, 8, 1, 0), aa_wd(T1, 0, 0), "R6");

        // R7: clear dirty only, then invalidate clean line
        wr(aa_addr(0, 9, 0, 1), aa_wd(T2, 0, 1));
        wr(aa_addr(0, 9, 0, 1), aa_wd(T2, 0, 0));
        rd(aa_addr(0, 9, 2, 0), aa_wd(T2, 0, 0), "R7");

        // R6: direct store clearing a dirty line writes back the old tag
        wr(aa_addr(1, 20, 0, 0), aa_wd(T3, 1, 1));
        for (int k = 0; k < 4; k++) wr(da_addr(1, 20, 0, k), 32'h5150_0000 + k);
        expect_wb({3'b000, T3, 7'd20, 4'b0},
                  {32'h5150_0003, 32'h5150_0002, 32'h5150_0001, 32'h5150_0000}, "R6 direct");
        wr(aa_addr(1, 20, 0, 0), aa_wd(T2, 0, 0));
        rd(aa_addr(1, 20, 0, 0), aa_wd(T2, 0, 0), "R6");

        // R10: other cache untouched
        rd(aa_addr(0, 20, 0, 0), 32'd0, "R10");
        rd(aa_addr(1, 8, 1, 0), 32'd0, "R10");

        // R1: outside the window
        wr(32'hE080_0088, aa_wd(T1, 1, 1));
        wr(32'hF200_0000 | (da_addr(0, 8, 1, 2) & 32'h00FF_FFFF), 32'h1234_5678);
        rd(32'hE080_0088, 32'd0, "R1");
        rd(aa_addr(0, 8, 1, 0) | 32'h2, 32'd0, "R1");
        rd(aa_addr(0, 8, 1, 0), aa_wd(T1, 0, 0), "R1");
        rd(da_addr(0, 8, 1, 2), 32'hA0A0_2222, "R1");

        // R4: associative store through the raw window address
        wr(32'hF080_0088, aa_wd(T1, 1, 1));
        rd(aa_addr(0, 8, 1, 0), aa_wd(T1, 1, 1), "R4");
        // R2: instruction data array, set 4 way 0 longword 3
        wr(32'hF100_004C, 32'hCAFE_0004);
        rd(32'hF100_004C, 32'hCAFE_0004, "R2");

        repeat (4) @(negedge clk);
        check(exp_wb_a.size() == 0, "R6 write-backs seen", exp_wb_a.size(), 0);
        check(exp_rd_q.size() == 0, "R9 loads answered", exp_rd_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule